// File: doc/BRIEF.md
# DMA Channel Microcode Sequencer

One channel thread of a programmable DMA engine. The block does not take a fixed descriptor. It runs a variable-length, byte-coded instruction stream that it reads from a program memory port. A start pulse, given while the thread is idle, supplies the address of the first instruction.

The thread can program its source address, its destination address and a control word. It can run two nested counted loops, which close with backward relative jumps. It moves data one beat at a time through a single-beat memory request port, parks until a chosen peripheral request line goes high, raises sticky event flags, and stops on an end instruction.

An illegal instruction or operand halts the thread. In that case the thread raises a fault flag with a type code, and the program counter keeps pointing at the offending instruction.

Top module: `dmaseq_thread`

## Requirements
- R1: After reset, busy, fault, mem_req and every event flag read 0.
- R2: A start pulse while idle begins fetching at start_pc and raises busy on the next cycle. A start pulse while busy has no effect on pc, fault or the running program.
- R3: Move is 6 bytes: 0xBC, then a selector byte (0 = source address, 1 = control word, 2 = destination address), then a 32-bit value least significant byte first. Any other selector stops the thread with fault code 2.
- R4: Loop start is 2 bytes: 0x20 with the loop index in bit 1, then count minus one, which is loaded into that counter. Loop end is 2 bytes: 0x28 with bit 4 set, the index in bit 2 and a qualifier in bits 1:0, then a backward distance. At a loop end, a nonzero counter is decremented and pc moves back by the distance; a zero counter falls through. Loops may nest.
- R5: Load (0x04 plus qualifier) performs one read at the source address. Its size code is taken from control bits 3:1, where codes 0, 1 and 2 mean 1, 2 and 4 bytes, and the code is presented on mem_size. If control bit 0 is set, the source address then advances by the size. The read word is held until the next store.
- R6: Store (0x08 plus qualifier) writes the held word to the destination address. Its size code is taken from control bits 17:15. If control bit 14 is set, the destination address then advances by the size. mem_priv equals control bit 22 during stores and is 0 otherwise.
- R7: A memory request holds its address, direction and data unchanged until mem_ack. Each acknowledged cycle completes exactly one transfer.
- R8: Wait-for-peripheral is 0x31 followed by the peripheral number shifted left by 3. The thread then stalls, with pc held and no transfers, until that peripheral's request line is high. Other request lines do not release it.
- R9: Send-event is 0x34 followed by the event number shifted left by 3. It sets that event flag, which stays set until the matching event_clr bit is pulsed.
- R10: End (0x00) drops busy. While idle, pc holds the address of the end instruction and no memory request is made.
- R11: An undefined byte stops the thread with fault code 1 and pc at that byte. This includes qualifier value 2 on load, store or loop end, and a loop end with bit 4 clear.
- R12: A size code above 2 at a load or store stops the thread with fault code 3 before any transfer. The same applies to a peripheral or event number beyond the number provided.
- R13: A new start clears the fault flag and the fault code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| start_pc | input | AW | First instruction address |
| busy | output | 1 | Thread running |
| pc | output | AW | Current instruction address |
| fault | output | 1 | Thread stopped on a fault |
| fault_code | output | 2 | 1 opcode, 2 register selector, 3 operand range |
| pm_addr | output | AW | Program memory byte address |
| pm_rdata | input | 8 | Program byte, same-cycle read |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_addr | output | DW | Transfer address |
| mem_size | output | 2 | Size code of the beat |
| mem_wdata | output | DW | Store data |
| mem_priv | output | 1 | Privileged store |
| mem_rdata | input | DW | Load data |
| mem_ack | input | 1 | Transfer completes this cycle |
| periph_req | input | NPERIPH | Peripheral request lines |
| event_flag | output | NEVENT | Sticky event flags |
| event_clr | input | NEVENT | Clear pulses for event flags |

## Verification
Some rules can be checked on every cycle by assertions. These are: a pending request holding steady until acknowledged; no request and a frozen pc while idle; a fault never coexisting with busy; a privileged marking only on stores; an event flag falling only after a clear; and a start while idle always producing busy.

Other behaviour needs the bench's programs: the decoded meaning of each instruction, loop iteration counts across nested loops, address stepping by size, the wait releasing only on the selected line, and the fault codes and pc values. A scoreboard compares every transfer against a list derived from the program text.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_EXEC, ST_XFER, ST_WAIT
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_END, OP_MOVE, OP_LOOP, OP_LEND, OP_LOAD,
        OP_STORE, OP_WAIT, OP_EVENT, OP_BAD
    } op_kind_e;

    // Control word fields kept by the thread
    typedef struct packed {
        logic       src_inc;
        logic [2:0] src_sz;
        logic       dst_inc;
        logic [2:0] dst_sz;
        logic       dst_priv;
    } ctl_t;

    localparam logic [1:0] FLT_NONE   = 2'd0;
    localparam logic [1:0] FLT_OPCODE = 2'd1;
    localparam logic [1:0] FLT_REGSEL = 2'd2;
    localparam logic [1:0] FLT_RANGE  = 2'd3;

endpackage

// File: rtl/dmaseq_decode.sv
module dmaseq_decode
    import dmaseq_pkg::*;
(
    input  logic [7:0] op_byte,
    output op_kind_e   kind,
    output logic [2:0] len
);
    always_comb begin
        kind = OP_BAD;
        len  = 3'd1;
        if (op_byte == 8'h00) begin
            kind = OP_END;
        end else if (op_byte == 8'hBC) begin
            kind = OP_MOVE;  len = 3'd6;
        end else if ((op_byte & 8'hFD) == 8'h20) begin
            kind = OP_LOOP;  len = 3'd2;
        end else if ((op_byte & 8'hF8) == 8'h38 && op_byte[1:0] != 2'b10) begin
            kind = OP_LEND;  len = 3'd2;
        end else if ((op_byte & 8'hFC) == 8'h04 && op_byte[1:0] != 2'b10) begin
            kind = OP_LOAD;
        end else if ((op_byte & 8'hFC) == 8'h08 && op_byte[1:0] != 2'b10) begin
            kind = OP_STORE;
        end else if (op_byte == 8'h31) begin
            kind = OP_WAIT;  len = 3'd2;
        end else if (op_byte == 8'h34) begin
            kind = OP_EVENT; len = 3'd2;
        end
    end
endmodule

// File: rtl/dmaseq_addr_step.sv
module dmaseq_addr_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] addr,
    input  logic [2:0]    size_code,
    input  logic          inc,
    output logic [DW-1:0] next_addr,
    output logic [1:0]    bus_size,
    output logic          size_ok
);
    always_comb begin
        size_ok   = (size_code <= 3'd2);
        bus_size  = size_code[1:0];
        next_addr = inc ? addr + (DW'(1) << size_code[1:0]) : addr;
    end
endmodule

// File: rtl/dmaseq_thread.sv
module dmaseq_thread
    import dmaseq_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 32,
    parameter int NPERIPH = 8,
    parameter int NEVENT  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      start_pc,
    output logic               busy,
    output logic [AW-1:0]      pc,
    output logic               fault,
    output logic [1:0]         fault_code,
    output logic [AW-1:0]      pm_addr,
    input  logic [7:0]         pm_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [DW-1:0]      mem_addr,
    output logic [1:0]         mem_size,
    output logic [DW-1:0]      mem_wdata,
    output logic               mem_priv,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ack,
    input  logic [NPERIPH-1:0] periph_req,
    output logic [NEVENT-1:0]  event_flag,
    input  logic [NEVENT-1:0]  event_clr
);
    localparam int PW = (NPERIPH > 1) ? $clog2(NPERIPH) : 1;
    localparam int EW = (NEVENT > 1) ? $clog2(NEVENT) : 1;

    typedef struct packed {
        seq_state_e      state;
        logic [AW-1:0]   pc;
        logic [2:0]      fcnt;
        logic [2:0]      ilen;
        logic [5:0][7:0] ib;
        logic [DW-1:0]   sar;
        logic [DW-1:0]   dar;
        logic [DW-1:0]   hold;
        ctl_t            ctl;
        logic [1:0][7:0] lc;
        logic [PW-1:0]   wsel;
        logic            fault;
        logic [1:0]      fcode;
        logic [NEVENT-1:0] evt;
    } thr_t;

    thr_t q, n;

    logic [7:0]  op_byte;
    op_kind_e    dec_kind;
    logic [2:0]  dec_len, cur_len;
    logic [31:0] word;
    logic        is_st;
    logic [1:0][DW-1:0] step_next;
    logic [1:0][1:0]    step_size;
    logic [1:0]         step_ok;

    assign op_byte = (q.state == ST_FETCH && q.fcnt == 3'd0) ? pm_rdata : q.ib[0];
    assign cur_len = (q.fcnt == 3'd0) ? dec_len : q.ilen;
    assign word    = {q.ib[5], q.ib[4], q.ib[3], q.ib[2]};
    assign is_st   = q.ib[0][3];

    dmaseq_decode u_dec (.op_byte(op_byte), .kind(dec_kind), .len(dec_len));

    // Index 0 steps the source side, index 1 the destination side
    for (genvar g = 0; g < 2; g++) begin : g_step
        dmaseq_addr_step #(.DW(DW)) u_step (
            .addr      ((g == 0) ? q.sar : q.dar),
            .size_code ((g == 0) ? q.ctl.src_sz : q.ctl.dst_sz),
            .inc       ((g == 0) ? q.ctl.src_inc : q.ctl.dst_inc),
            .next_addr (step_next[g]),
            .bus_size  (step_size[g]),
            .size_ok   (step_ok[g])
        );
    end

    always_comb begin
        n     = q;
        n.evt = q.evt & ~event_clr;
        case (q.state)
            ST_IDLE: if (start) begin
                n.state = ST_FETCH;
                n.pc    = start_pc;
                n.fcnt  = 3'd0;
                n.fault = 1'b0;
                n.fcode = FLT_NONE;
            end
            ST_FETCH: begin
                for (int i = 0; i < 6; i++)
                    if (q.fcnt == 3'(i)) n.ib[i] = pm_rdata;
                if (q.fcnt == 3'd0) n.ilen = dec_len;
                if (q.fcnt == 3'd0 && dec_kind == OP_BAD) begin
                    n.state = ST_IDLE;
                    n.fault = 1'b1;
                    n.fcode = FLT_OPCODE;
                end else if (q.fcnt + 3'd1 == cur_len) begin
                    n.state = ST_EXEC;
                    n.fcnt  = 3'd0;
                end else begin
                    n.fcnt = q.fcnt + 3'd1;
                end
            end
            ST_EXEC: begin
                n.state = ST_FETCH;
                case (dec_kind)
                    OP_MOVE: begin
                        n.pc = q.pc + AW'(6);
                        case (q.ib[1])
                            8'd0: n.sar = DW'(word);
                            8'd1: n.ctl = '{src_inc: word[0], src_sz: word[3:1],
                                            dst_inc: word[14], dst_sz: word[17:15],
                                            dst_priv: word[22]};
                            8'd2: n.dar = DW'(word);
                            default: begin
                                n.pc = q.pc; n.state = ST_IDLE;
                                n.fault = 1'b1; n.fcode = FLT_REGSEL;
                            end
                        endcase
                    end
                    OP_LOOP: begin
                        n.lc[q.ib[0][1]] = q.ib[1];
                        n.pc = q.pc + AW'(2);
                    end
                    OP_LEND: begin
                        if (q.lc[q.ib[0][2]] != 8'd0) begin
                            n.lc[q.ib[0][2]] = q.lc[q.ib[0][2]] - 8'd1;
                            n.pc = q.pc - AW'(q.ib[1]);
                        end else begin
                            n.pc = q.pc + AW'(2);
                        end
                    end
                    OP_LOAD, OP_STORE: begin
                        if (step_ok[is_st]) n.state = ST_XFER;
                        else begin
                            n.state = ST_IDLE; n.fault = 1'b1; n.fcode = FLT_RANGE;
                        end
                    end
                    OP_WAIT: begin
                        if (32'(q.ib[1][7:3]) >= NPERIPH) begin
                            n.state = ST_IDLE; n.fault = 1'b1; n.fcode = FLT_RANGE;
                        end else begin
                            n.wsel  = PW'(q.ib[1][7:3]);
                            n.state = ST_WAIT;
                        end
                    end
                    OP_EVENT: begin
                        if (32'(q.ib[1][7:3]) >= NEVENT) begin
                            n.state = ST_IDLE; n.fault = 1'b1; n.fcode = FLT_RANGE;
                        end else begin
                            n.evt[EW'(q.ib[1][7:3])] = 1'b1;
                            n.pc = q.pc + AW'(2);
                        end
                    end
                    OP_END: n.state = ST_IDLE;
                    default: begin
                        n.state = ST_IDLE; n.fault = 1'b1; n.fcode = FLT_OPCODE;
                    end
                endcase
            end
            ST_XFER: if (mem_ack) begin
                if (is_st) n.dar = step_next[1];
                else begin
                    n.sar  = step_next[0];
                    n.hold = mem_rdata;
                end
                n.pc    = q.pc + AW'(1);
                n.state = ST_FETCH;
            end
            ST_WAIT: if (periph_req[q.wsel]) begin
                n.pc    = q.pc + AW'(2);
                n.state = ST_FETCH;
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= n;
    end

    assign busy       = (q.state != ST_IDLE);
    assign pc         = q.pc;
    assign fault      = q.fault;
    assign fault_code = q.fcode;
    assign pm_addr    = q.pc + AW'(q.fcnt);
    assign mem_req    = (q.state == ST_XFER);
    assign mem_we     = mem_req && is_st;
    assign mem_addr   = is_st ? q.dar : q.sar;
    assign mem_size   = is_st ? step_size[1] : step_size[0];
    assign mem_wdata  = q.hold;
    assign mem_priv   = mem_req && is_st && q.ctl.dst_priv;
    assign event_flag = q.evt;

endmodule

// File: rtl/dmaseq_thread_chk.sv
module dmaseq_thread_chk #(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int NEVENT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [AW-1:0]     pc,
    input logic              fault,
    input logic [1:0]        fault_code,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [DW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_priv,
    input logic [NEVENT-1:0] event_flag,
    input logic [NEVENT-1:0] event_clr
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_priv_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_priv |-> (mem_req && mem_we));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    p_event_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_flag & ~event_clr) != '0) |=>
            (($past(event_flag & ~event_clr) & ~event_flag) == '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(pc));

    p_fault_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && fault_code != 2'd0));
endmodule

bind dmaseq_thread dmaseq_thread_chk #(.AW(AW), .DW(DW), .NEVENT(NEVENT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pc(pc),
    .fault(fault), .fault_code(fault_code), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_priv(mem_priv),
    .event_flag(event_flag), .event_clr(event_clr)
);

// File: tb/dmaseq_thread_bench.sv
module dmaseq_thread_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NP = 8;
    localparam int NE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_pc = '0;
    logic busy, fault, mem_req, mem_we, mem_priv;
    logic [AW-1:0] pc, pm_addr;
    logic [1:0] fault_code, mem_size;
    logic [7:0] pm_rdata;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
    logic mem_ack = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic [NE-1:0] event_flag;
    logic [NE-1:0] event_clr = '0;

    always #2.5 clk = ~clk;

    logic [7:0] prog [0:255];
    assign pm_rdata = prog[pm_addr];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1234_0000;
    endfunction
    assign mem_rdata = rd(mem_addr);

    dmaseq_thread #(.AW(AW), .DW(DW), .NPERIPH(NP), .NEVENT(NE)) u_dmaseq_thread (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .busy(busy), .pc(pc), .fault(fault), .fault_code(fault_code),
        .pm_addr(pm_addr), .pm_rdata(pm_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_priv(mem_priv), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .periph_req(periph_req),
        .event_flag(event_flag), .event_clr(event_clr)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        priv;
    } xfer_t;

    xfer_t exp_q[$];
    int ntot = 0, nfail = 0, nseen = 0, wp = 0, cyc = 0;
    bit timed_out = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic emit(input logic [7:0] b);
        prog[wp[7:0]] = b;
        wp++;
    endtask

    task automatic mov(input logic [7:0] sel, input logic [31:0] v);
        emit(8'hBC); emit(sel);
        emit(v[7:0]); emit(v[15:8]); emit(v[23:16]); emit(v[31:24]);
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic pv);
        xfer_t x;
        x.we = we; x.addr = a; x.size = sz; x.wdata = wd; x.priv = pv;
        exp_q.push_back(x);
    endtask

    // Memory model and scoreboard monitor: a transfer is compared when acknowledged
    int lat = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (lat >= 2) begin
                lat = 0;
                mem_ack = 1'b1;
                nseen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected transfer", mem_addr, 32'h0);
                end else begin
                    xfer_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr && mem_size == e.size
                        && mem_priv == e.priv && (!e.we || mem_wdata == e.wdata),
                        e.we ? "R6 store" : "R5 load",
                        {mem_addr[23:0], 2'b0, mem_size, 2'b0, mem_priv, mem_we},
                        {e.addr[23:0], 2'b0, e.size, 2'b0, e.priv, e.we});
                    if (e.we) chk(mem_wdata == e.wdata, "R6 held data", mem_wdata, e.wdata);
                end
            end else begin
                lat++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            timed_out = 1'b1;
            ntot++; nfail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", ntot - nfail, ntot);
            $finish;
        end
    end

    task automatic kick(input logic [AW-1:0] sp);
        @(negedge clk); start_pc = sp; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run();
        while (busy && !timed_out) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) prog[i] = 8'hFF;
        // Copy program: 3 beats of 4 bytes, both sides incrementing
        wp = 'h10;
        mov(8'd1, 32'h0001_4005);
        mov(8'd0, 32'h0000_1000);
        mov(8'd2, 32'h0000_2000);
        emit(8'h20); emit(8'd2);         // R4 loop 0, 3 passes
        emit(8'h05); emit(8'h09);        // 0x24 load, 0x25 store
        emit(8'h39); emit(8'd2);         // 0x26 loop end back to 0x24
        emit(8'h34); emit(8'h00);        // event 0
        emit(8'h00);                     // 0x2A end
        // Nested program: fixed source, 2-byte beats, privileged stores
        wp = 'h40;
        mov(8'd1, 32'h0040_C002);
        mov(8'd0, 32'h0000_3000);
        mov(8'd2, 32'h0000_4000);
        emit(8'h20); emit(8'd1);         // 0x52 outer, 2 passes
        emit(8'h22); emit(8'd2);         // 0x54 inner, 3 passes
        emit(8'h31); emit(8'h08);        // 0x56 wait peripheral 1
        emit(8'h07); emit(8'h0B);        // 0x58 load, 0x59 store
        emit(8'h3F); emit(8'd4);         // 0x5A inner end -> 0x56
        emit(8'h3B); emit(8'd8);         // 0x5C outer end -> 0x54
        emit(8'h34); emit(8'h10);        // 0x5E event 2
        emit(8'h00);                     // 0x60 end
        wp = 'h80; emit(8'h06);          // reserved qualifier
        wp = 'h90; mov(8'd3, 32'h0);     // bad selector
        wp = 'hA0; mov(8'd1, 32'h6); emit(8'h04); // size code 3 then load at 0xA6
        wp = 'hB0; emit(8'h00);
        wp = 'hC0; emit(8'h28); emit(8'h00);      // loop end without bit 4

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 busy", 32'(busy), 0);
        chk(!fault, "R1 fault", 32'(fault), 0);
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        chk(event_flag == '0, "R1 events", 32'(event_flag), 0);

        // R3 R4 R5 R6: plain copy
        for (int i = 0; i < 3; i++) begin
            push(1'b0, 32'h1000 + 32'(4*i), 2'd2, 32'h0, 1'b0);
            push(1'b1, 32'h2000 + 32'(4*i), 2'd2, rd(32'h1000 + 32'(4*i)), 1'b0);
        end
        kick(8'h10);
        chk(busy, "R2 busy after start", 32'(busy), 1);
        finish_run();
        chk(exp_q.size() == 0, "R4 all copy beats", 32'(exp_q.size()), 0);
        chk(pc == 8'h2A, "R10 pc at end", 32'(pc), 32'h2A);
        chk(!fault, "R10 no fault", 32'(fault), 0);
        chk(event_flag == 4'b0001, "R9 event 0", 32'(event_flag), 1);

        // R8 R4 nested loops with wait, R2 start ignored while busy
        for (int i = 0; i < 6; i++) begin
            push(1'b0, 32'h3000, 2'd1, 32'h0, 1'b0);
            push(1'b1, 32'h4000 + 32'(2*i), 2'd1, rd(32'h3000), 1'b1);
        end
        nseen = 0;
        kick(8'h40);
        repeat (40) @(negedge clk);
        chk(busy, "R8 stalled busy", 32'(busy), 1);
        chk(pc == 8'h56, "R8 pc held", 32'(pc), 32'h56);
        chk(nseen == 0, "R8 no transfer", 32'(nseen), 0);
        periph_req = 8'h01;
        repeat (10) @(negedge clk);
        chk(pc == 8'h56 && nseen == 0, "R8 other line", 32'(pc), 32'h56);
        kick(8'h80);
        repeat (3) @(negedge clk);
        chk(pc == 8'h56 && !fault && busy, "R2 start ignored", 32'(pc), 32'h56);
        periph_req = 8'h02;
        finish_run();
        chk(exp_q.size() == 0, "R4 nested beats", 32'(exp_q.size()), 0);
        chk(pc == 8'h60, "R10 pc nested end", 32'(pc), 32'h60);
        chk(event_flag == 4'b0101, "R9 events sticky", 32'(event_flag), 5);
        @(negedge clk); event_clr = 4'b0100;
        @(negedge clk); event_clr = 4'b0000;
        chk(event_flag == 4'b0001, "R9 clear one", 32'(event_flag), 1);
        periph_req = '0;

        // R11 undefined byte
        kick(8'h80); finish_run();
        chk(fault && fault_code == 2'd1, "R11 code", 32'(fault_code), 1);
        chk(pc == 8'h80, "R11 pc", 32'(pc), 32'h80);
        kick(8'hC0); finish_run();
        chk(fault && fault_code == 2'd1 && pc == 8'hC0, "R11 loop end form", 32'(pc), 32'hC0);

        // R3 bad selector
        kick(8'h90); finish_run();
        chk(fault && fault_code == 2'd2, "R3 selector fault", 32'(fault_code), 2);
        chk(pc == 8'h90, "R3 pc", 32'(pc), 32'h90);

        // R12 bad size, no transfer
        nseen = 0;
        kick(8'hA0); finish_run();
        chk(fault && fault_code == 2'd3, "R12 size fault", 32'(fault_code), 3);
        chk(pc == 8'hA6 && nseen == 0, "R12 pc no transfer", 32'(pc), 32'hA6);

        // R13 fault cleared by a new start
        kick(8'hB0); finish_run();
        chk(!fault && fault_code == 2'd0, "R13 cleared", 32'(fault_code), 0);
        chk(pc == 8'hB0 && !mem_req, "R10 idle at end", 32'(pc), 32'hB0);

        done = 1'b1;
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end
endmodule